// File: doc/BRIEF.md
# Transport Stream Ring-Buffer Writer

This block takes a byte-wide transport stream and lays it down in a circular region of memory. Incoming bytes are gathered four at a time into 32-bit words. Each finished word leaves through a simple write port that carries an address, data and a one-cycle strobe. The write offset runs from zero up to a programmed ring length and then starts again at the base address. Capture always begins on a packet boundary. Packets are normally 188 bytes and open with the sync byte 0x47, so they lie back to back in the ring at multiples of the packet length.

Software sets the block up through a small register file with word indices. It can read back the absolute address of the next word write and subtract the base from it to find the fill level. An interrupt is raised once every N completed packets. The status is cleared by writing ones back to it, so writing back the value just read clears exactly what was seen. A restart strobe rewinds the ring to its base.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset the write strobe and the interrupt line are low, the write pointer reads 0 and the status reads 0. The packet length register reads 188 and the packets-per-interrupt register reads 47.
- R2: While enabled, bytes that arrive before the first packet-start strobe are discarded. This applies after reset, after a restart and after re-enabling. Such bytes cause no write and do not move the pointer.
- R3: Accepted bytes are packed little-endian: the k-th byte of a word sits at bits 8k+7:8k. Each group of four accepted bytes produces exactly one write, presented in the cycle after the fourth byte is accepted, at address base plus the current offset.
- R4: After each write the offset advances by 4. When offset+4 reaches or exceeds the ring length, the offset returns to 0 instead.
- R5: Register index 8 reads base plus the current offset. Indices 0 to 5 read back what was written: enable in bit 0, base, ring length, packet length, packets per interrupt, and mask in bit 0. Index 6 reads the status in bit 0. Unused indices read 0.
- R6: A packet completes when packet-length bytes have been accepted since the capture point. When the completion count reaches the value in index 4 (at least 1), status bit 0 is set and the count reloads to 0.
- R7: Writing index 6 with bit 0 set clears the status. Writing it with bit 0 clear has no effect. If a status set and a clear fall in the same cycle, the set wins.
- R8: The interrupt line is high exactly when the enable bit, the mask bit and the status bit are all 1.
- R9: Writing index 7 with bit 0 set rewinds the offset to 0, drops any partial word, reloads the packet counter and waits for a new packet start. The status is kept.
- R10: While enable is 0, nothing is accepted and no write is issued, and the partial word and packet position are dropped. The offset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_valid | input | 1 | Input byte valid |
| ts_start | input | 1 | Marks the first byte of a packet |
| ts_byte | input | 8 | Stream byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | 32 | Word write address |
| mem_wdata | output | 32 | Word write data |
| irq | output | 1 | Interrupt line |

## Verification
Some internal faults show at the data and address of the next word write, one cycle after the fourth byte of the word is accepted. These are a lane counter that slips, a capture flag that opens without a packet start, and an offset that wraps one word early or late. A wrong packet counter stays hidden until the programmed number of packets has passed, and then shows as an interrupt that comes one packet early or late. For that reason the bench runs several whole interrupt periods, compares the write port and the interrupt line against a behavioural model on every clock, and reads the pointer back after each phase.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;
  localparam int WORD_BYTES = 4;
  localparam int REG_AW     = 4;

  localparam logic [REG_AW-1:0] IDX_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] IDX_BASE    = 4'd1;
  localparam logic [REG_AW-1:0] IDX_RLEN    = 4'd2;
  localparam logic [REG_AW-1:0] IDX_PLEN    = 4'd3;
  localparam logic [REG_AW-1:0] IDX_PPI     = 4'd4;
  localparam logic [REG_AW-1:0] IDX_MASK    = 4'd5;
  localparam logic [REG_AW-1:0] IDX_STATUS  = 4'd6;
  localparam logic [REG_AW-1:0] IDX_RESTART = 4'd7;
  localparam logic [REG_AW-1:0] IDX_WPTR    = 4'd8;

  localparam int DEF_PLEN = 188;
  localparam int DEF_PPI  = 47;
endpackage

// File: rtl/ts_byte_packer.sv
module ts_byte_packer #(
  parameter int PKT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             in_valid_i,
  input  logic             in_sop_i,
  input  logic [7:0]       in_data_i,
  input  logic [PKT_W-1:0] pkt_len_i,
  output logic             word_fire_o,
  output logic             pkt_done_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_wdata_o
);
  logic             cap_q, cap_d;
  logic [1:0]       lane_q, lane_d;
  logic [23:0]      hold_q, hold_d;
  logic [PKT_W-1:0] bcnt_q, bcnt_d;
  logic             we_d;
  logic [31:0]      wd_d;
  logic             accept;

  assign accept      = en_i && !clr_i && in_valid_i && (cap_q || in_sop_i);
  assign word_fire_o = accept && (lane_q == 2'd3);
  assign pkt_done_o  = accept && (bcnt_q == pkt_len_i - 1'b1);

  always_comb begin
    cap_d  = cap_q;
    lane_d = lane_q;
    hold_d = hold_q;
    bcnt_d = bcnt_q;
    we_d   = word_fire_o;
    wd_d   = mem_wdata_o;
    if (clr_i || !en_i) begin
      cap_d  = 1'b0;
      lane_d = 2'd0;
      bcnt_d = '0;
    end else if (accept) begin
      cap_d = 1'b1;
      case (lane_q)
        2'd0: hold_d[7:0]   = in_data_i;
        2'd1: hold_d[15:8]  = in_data_i;
        2'd2: hold_d[23:16] = in_data_i;
        default: wd_d = {in_data_i, hold_q};
      endcase
      lane_d = lane_q + 2'd1;
      bcnt_d = pkt_done_o ? '0 : bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q       <= 1'b0;
      lane_q      <= 2'd0;
      hold_q      <= '0;
      bcnt_q      <= '0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      cap_q       <= cap_d;
      lane_q      <= lane_d;
      hold_q      <= hold_d;
      bcnt_q      <= bcnt_d;
      mem_we_o    <= we_d;
      mem_wdata_o <= wd_d;
    end
  end

  assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mem_we_o);
  assert_one_per_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/ts_ring_addr.sv
module ts_ring_addr
  import ts_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              word_fire_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  ring_len_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] wptr_o
);
  localparam logic [LEN_W:0] STEP = (LEN_W+1)'(WORD_BYTES);

  logic [LEN_W-1:0]  off_q, off_d;
  logic [ADDR_W-1:0] addr_d;
  logic              wrap;

  assign wrap   = ({1'b0, off_q} + STEP) >= {1'b0, ring_len_i};
  assign wptr_o = base_i + ADDR_W'(off_q);

  always_comb begin
    off_d  = off_q;
    addr_d = mem_addr_o;
    if (clr_i) begin
      off_d = '0;
    end else if (word_fire_i) begin
      addr_d = wptr_o;
      off_d  = wrap ? '0 : off_q + LEN_W'(WORD_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q      <= '0;
      mem_addr_o <= '0;
    end else begin
      off_q      <= off_d;
      mem_addr_o <= addr_d;
    end
  end

  assert_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (off_q == '0));
  assert_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire_i && !clr_i && ring_len_i != '0) |=> (off_q < $past(ring_len_i)));
endmodule

// File: rtl/ts_irq_ctrl.sv
module ts_irq_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pkt_done_i,
  input  logic [CNT_W-1:0] ppi_i,
  input  logic             st_clr_i,
  input  logic             en_i,
  input  logic             mask_i,
  output logic             status_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_d;
  logic             hit;

  assign hit   = pkt_done_i && (cnt_q == ppi_i - 1'b1);
  assign irq_o = en_i && mask_i && status_o;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)           cnt_d = '0;
    else if (pkt_done_i) cnt_d = hit ? '0 : cnt_q + 1'b1;
    st_d = status_o;
    if (hit)           st_d = 1'b1;
    else if (st_clr_i) st_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      status_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      status_o <= st_d;
    end
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_i && mask_i));
  assert_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(pkt_done_i));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_i && !pkt_done_i) |=> !status_o);
endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer
  import ts_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int PKT_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_valid,
  input  logic              ts_start,
  input  logic [7:0]        ts_byte,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              irq
);
  logic              en_q, en_d, mask_q, mask_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  rlen_q, rlen_d;
  logic [PKT_W-1:0]  plen_q, plen_d;
  logic [CNT_W-1:0]  ppi_q, ppi_d;
  logic              restart, st_clr, word_fire, pkt_done, status;
  logic [ADDR_W-1:0] wptr;

  assign restart = cfg_we && (cfg_addr == IDX_RESTART) && cfg_wdata[0];
  assign st_clr  = cfg_we && (cfg_addr == IDX_STATUS) && cfg_wdata[0];

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    base_d = base_q;
    rlen_d = rlen_q;
    plen_d = plen_q;
    ppi_d  = ppi_q;
    if (cfg_we) begin
      case (cfg_addr)
        IDX_CTRL: en_d   = cfg_wdata[0];
        IDX_BASE: base_d = cfg_wdata[ADDR_W-1:0];
        IDX_RLEN: rlen_d = cfg_wdata[LEN_W-1:0];
        IDX_PLEN: plen_d = cfg_wdata[PKT_W-1:0];
        IDX_PPI:  ppi_d  = cfg_wdata[CNT_W-1:0];
        IDX_MASK: mask_d = cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      base_q <= '0;
      rlen_q <= '0;
      plen_q <= PKT_W'(DEF_PLEN);
      ppi_q  <= CNT_W'(DEF_PPI);
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      base_q <= base_d;
      rlen_q <= rlen_d;
      plen_q <= plen_d;
      ppi_q  <= ppi_d;
    end
  end

  always_comb begin
    case (cfg_addr)
      IDX_CTRL:   cfg_rdata = {31'd0, en_q};
      IDX_BASE:   cfg_rdata = 32'(base_q);
      IDX_RLEN:   cfg_rdata = 32'(rlen_q);
      IDX_PLEN:   cfg_rdata = 32'(plen_q);
      IDX_PPI:    cfg_rdata = 32'(ppi_q);
      IDX_MASK:   cfg_rdata = {31'd0, mask_q};
      IDX_STATUS: cfg_rdata = {31'd0, status};
      IDX_WPTR:   cfg_rdata = 32'(wptr);
      default:    cfg_rdata = '0;
    endcase
  end

  ts_byte_packer #(.PKT_W(PKT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .clr_i(restart),
    .in_valid_i(ts_valid), .in_sop_i(ts_start), .in_data_i(ts_byte),
    .pkt_len_i(plen_q), .word_fire_o(word_fire), .pkt_done_o(pkt_done),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  ts_ring_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .word_fire_i(word_fire),
    .base_i(base_q), .ring_len_i(rlen_q), .mem_addr_o(mem_addr), .wptr_o(wptr)
  );

  ts_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr_i(restart), .pkt_done_i(pkt_done),
    .ppi_i(ppi_q), .st_clr_i(st_clr), .en_i(en_q), .mask_i(mask_q),
    .status_o(status), .irq_o(irq)
  );
endmodule

// File: tb/ts_ring_writer_test.sv
module ts_ring_writer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, ts_valid, ts_start, cfg_we;
  logic [7:0]  ts_byte;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata;
  logic        mem_we, irq;

  ts_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_start(ts_start),
    .ts_byte(ts_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  int checks = 0, fails = 0, wr_seen = 0;
  bit finished = 0;
  logic [31:0] last_data;

  // behavioural reference model
  bit          m_en, m_mask, m_st, m_cap, e_we;
  logic [31:0] m_base, e_addr, e_data;
  int          m_rlen, m_plen, m_ppi, m_lane, m_bc, m_pc, m_off;
  logic [7:0]  m_b [4];

  always @(posedge clk or negedge rst_n) begin
    bit acc, setf, clr;
    if (!rst_n) begin
      m_en = 0; m_mask = 0; m_st = 0; m_cap = 0; e_we = 0;
      m_base = 0; m_rlen = 0; m_plen = 188; m_ppi = 47;
      m_lane = 0; m_bc = 0; m_pc = 0; m_off = 0;
    end else begin
      clr  = cfg_we && cfg_addr == 4'd7 && cfg_wdata[0];
      e_we = 0; setf = 0;
      acc  = m_en && !clr && ts_valid && (m_cap || ts_start);
      if (clr || !m_en) begin
        m_cap = 0; m_lane = 0; m_bc = 0;
        if (clr) begin m_off = 0; m_pc = 0; end
      end else if (acc) begin
        m_cap = 1;
        m_b[m_lane] = ts_byte;
        if (m_lane == 3) begin
          e_we = 1; e_addr = m_base + m_off;
          e_data = {m_b[3], m_b[2], m_b[1], m_b[0]};
          m_off = (m_off + 4 >= m_rlen) ? 0 : m_off + 4;
          m_lane = 0;
        end else m_lane++;
        if (m_bc == m_plen - 1) begin
          m_bc = 0;
          if (m_pc == m_ppi - 1) begin m_pc = 0; setf = 1; end else m_pc++;
        end else m_bc++;
      end
      if (setf) m_st = 1;
      else if (cfg_we && cfg_addr == 4'd6 && cfg_wdata[0]) m_st = 0;
      if (cfg_we) case (cfg_addr)
        4'd0: m_en   = cfg_wdata[0];
        4'd1: m_base = cfg_wdata;
        4'd2: m_rlen = int'(cfg_wdata[23:0]);
        4'd3: m_plen = int'(cfg_wdata[7:0]);
        4'd4: m_ppi  = int'(cfg_wdata[7:0]);
        4'd5: m_mask = cfg_wdata[0];
        default: ;
      endcase
    end
  end

  // per-clock comparison of the write port (R3, R4) and interrupt (R8)
  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if (mem_we !== e_we || (e_we && (mem_addr !== e_addr || mem_wdata !== e_data))) begin
      fails++;
      $display("FAIL R3/R4 write port: got we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
               mem_we, mem_addr, mem_wdata, e_we, e_addr, e_data);
    end
    checks++;
    if (irq !== (m_en & m_st & m_mask)) begin
      fails++;
      $display("FAIL R8 irq: got %0b expected %0b", irq, m_en & m_st & m_mask);
    end
    if (mem_we) begin wr_seen++; last_data = mem_wdata; end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    cfg_addr = a; @(negedge clk); v = cfg_rdata; step();
  endtask

  task automatic send(input logic [7:0] d, input bit sop);
    ts_valid = 1; ts_start = sop; ts_byte = d; step();
    ts_valid = 0; ts_start = 0;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed, input bit gaps);
    for (int i = 0; i < len; i++) begin
      send(i == 0 ? 8'h47 : seed + 8'(i), i == 0);
      if (gaps && i[0]) step();
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    int w0;
    rst_n = 0; ts_valid = 0; ts_start = 0; ts_byte = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(4'd8, v); chk("R1 wptr", v, 0);
    rd(4'd6, v); chk("R1 status", v, 0);
    rd(4'd3, v); chk("R1 pkt len", v, 188);
    rd(4'd4, v); chk("R1 ppi", v, 47);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 mem_we", {31'd0, mem_we}, 0);

    wr(4'd1, 32'h1000); wr(4'd2, 48); wr(4'd3, 12); wr(4'd4, 2);
    wr(4'd5, 1); wr(4'd0, 1);
    rd(4'd2, v); chk("R5 ring len readback", v, 48);
    rd(4'd9, v); chk("R5 unused index", v, 0);

    // R2: bytes before a packet start are dropped
    for (int i = 0; i < 5; i++) send(8'hA0 + 8'(i), 0);
    step();
    chk("R2 no writes", wr_seen, 0);
    rd(4'd8, v); chk("R2 wptr unchanged", v, 32'h1000);

    // R3/R5: one packet, gaps in the stream
    send_pkt(12, 8'h10, 1); step();
    chk("R3 write count", wr_seen, 3);
    chk("R3 last word", last_data, 32'h1B1A1918);
    rd(4'd8, v); chk("R5 wptr", v, 32'h100C);
    rd(4'd6, v); chk("R6 status after 1 pkt", v, 0);

    // R6/R8: second packet raises status and irq
    send_pkt(12, 8'h20, 0); step();
    rd(4'd6, v); chk("R6 status after 2 pkts", v, 1);
    chk("R8 irq on", {31'd0, irq}, 1);
    wr(4'd5, 0); chk("R8 irq masked", {31'd0, irq}, 0);
    wr(4'd5, 1); chk("R8 irq unmasked", {31'd0, irq}, 1);

    // R7: write-one-to-clear
    wr(4'd6, 0); rd(4'd6, v); chk("R7 zero write ignored", v, 1);
    rd(4'd6, v); wr(4'd6, v); rd(4'd6, v); chk("R7 read-write clears", v, 0);

    // R4: wrap to base after 48 bytes
    send_pkt(12, 8'h30, 0); send_pkt(12, 8'h40, 1); step();
    rd(4'd8, v); chk("R4 wrap to base", v, 32'h1000);
    rd(4'd6, v); chk("R6 status period 2", v, 1);

    // R7: set wins over a same-cycle clear
    wr(4'd6, 1);
    send_pkt(12, 8'h50, 0);
    for (int i = 0; i < 11; i++) send(i == 0 ? 8'h47 : 8'h60 + 8'(i), i == 0);
    ts_valid = 1; ts_byte = 8'h6B; cfg_we = 1; cfg_addr = 4'd6; cfg_wdata = 1;
    step(); ts_valid = 0; cfg_we = 0;
    rd(4'd6, v); chk("R7 set wins", v, 1);
    wr(4'd6, 1);

    // R9: restart drops partial word and requires a new start
    send_pkt(6, 8'h70, 0);
    wr(4'd7, 1);
    rd(4'd8, v); chk("R9 wptr rewound", v, 32'h1000);
    w0 = wr_seen;
    for (int i = 0; i < 4; i++) send(8'h80 + 8'(i), 0);
    step(); chk("R9 no capture before start", wr_seen, w0);
    send(8'h47, 1); send(8'h91, 0); send(8'h92, 0); send(8'h93, 0); step();
    chk("R9 aligned first word", last_data, 32'h93929147);
    for (int i = 4; i < 12; i++) send(8'h90 + 8'(i), 0);
    step(); rd(4'd6, v); chk("R9 counter reloaded", v, 0);

    // R10: disable stops capture and drops the partial word
    send(8'h47, 1); send(8'h01, 0);
    wr(4'd0, 0);
    w0 = wr_seen;
    send_pkt(12, 8'hA0, 0); step();
    chk("R10 no writes while off", wr_seen, w0);
    wr(4'd0, 1);
    send(8'h55, 0); send(8'h56, 0);
    send_pkt(12, 8'hB0, 0); step();
    chk("R10 restart aligned", wr_seen, w0 + 3);
    rd(4'd6, v); chk("R10 status after re-enable", v, 1);
    wr(4'd0, 0); chk("R8 irq off when disabled", {31'd0, irq}, 0);
    wr(4'd6, 1); wr(4'd0, 1);

    // R6 with nominal packet length
    wr(4'd7, 1); wr(4'd2, 4096); wr(4'd3, 188); wr(4'd1, 32'h2000);
    send_pkt(188, 8'h00, 0); step();
    rd(4'd6, v); chk("R6 one of two nominal", v, 0);
    send_pkt(188, 8'h40, 1); step();
    rd(4'd6, v); chk("R6 two nominal packets", v, 1);
    rd(4'd8, v); chk("R5 wptr nominal", v, 32'h2000 + 376);
    repeat (3) step();
    summary();
  end
endmodule